// File: doc/BRIEF.md
# Differential PWM Output Stage

This block turns a stream of signed PCM samples, already interpolated and reduced to the PWM resolution, into a complementary pair of two-state pulse outputs, `pwm_p` and `pwm_m`, that drive an external H-bridge. A free-running counter divides time into PWM frames whose length in clock cycles is set by the `frame_len` input. One sample is used per frame. In each frame the positive output is high for half the frame plus the sample value, so a zero sample gives a 50% duty waveform. The usable offset is clipped so that a full-scale input never produces a 0% or 100% duty frame, which keeps the modulation index a little below one.

Two mute controls override the data. Quiet mute sends the zero-signal waveform, with 50% duty on both outputs. Hard mute parks the bridge with `pwm_p` low and `pwm_m` high. A mode state machine has three states: `ST_HARD` (parked), `ST_QUIET` (zero-signal frames) and `ST_RUN` (sample-driven frames). Its transitions are:
- `T_HARD_ENTER`: from any state, on the first clock edge with `hard_mute` high.
- `T_RELEASE_QUIET` and `T_RELEASE_RUN`: from `ST_HARD` at a frame boundary, once `hard_mute` is low.
- `T_TO_QUIET` and `T_TO_RUN`: between `ST_QUIET` and `ST_RUN` at a frame boundary.

The sample, the frame length and the quiet selection are all taken only at a frame boundary. The `frame_start` output marks the first output cycle of every frame.

Top module: `dpwm_bridge_out`

## Requirements
- R1: `pwm_p` and `pwm_m` always differ, including during and directly after reset.
- R2: While `rst_n` is low, `pwm_p`=0, `pwm_m`=1 and `frame_start`=0. The first frame after reset lasts the default length of 64 cycles and is hard-muted.
- R3: Once `hard_mute` is high at a clock edge, from the second following edge `pwm_p` is 0 and `pwm_m` is 1. This holds until the first frame boundary after `hard_mute` returns low.
- R4: In a data frame of length L, `pwm_p` is high for the first L/2 + s cycles and low for the rest, where s is the sample as a two's-complement value. `pwm_m` is the complement of `pwm_p`.
- R5: The offset s is clipped to ±(L/2 − floor(L/32) − 1). For L=64 a sample of 127 gives 61 high cycles and a sample of −128 gives 3. A frame is therefore never all high or all low.
- R6: Changes to the sample, the frame length or `quiet_mute` within a frame have no effect on it. Only the values present at the frame boundary count. `pwm_p` falls at most once per frame.
- R7: In a quiet frame `pwm_p` is high for exactly L/2 cycles, whatever the sample.
- R8: Hard mute overrides quiet mute, and quiet mute overrides the data.
- R9: A frame lasts exactly the `frame_len` value taken at its boundary (an even value of at least 4). `frame_start` is high in the first output cycle of each frame only.
- R10: When hard mute is released, the next frame is quiet or data according to `quiet_mute` at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hard_mute | input | 1 | Park the bridge: P low, M high |
| quiet_mute | input | 1 | Output the zero-signal 50% waveform |
| pcm_sample | input | SMP_W (8) | Signed sample in PWM counts |
| frame_len | input | CNT_W (8) | Frame length in cycles, even, at least 4 |
| pwm_p | output | 1 | Positive bridge drive |
| pwm_m | output | 1 | Negative bridge drive |
| frame_start | output | 1 | High in the first output cycle of a frame |

## Verification
The checker enforces these rules on every cycle:
- The outputs never share a level.
- The two-edge hard-mute latency holds.
- Every frame ends with `pwm_p` low.
- There is at most one falling edge of `pwm_p` per frame.
- `frame_start` never appears in two cycles in a row.

The exact number of high cycles per frame can only be shown by the bench scenarios. These cover the clipping limits, quiet and hard priority, mid-frame disturbances of the inputs, release from hard mute and changes of frame length. Each measured frame is compared with a value predicted from the requirements.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    typedef enum logic [1:0] {
        ST_HARD  = 2'd0,
        ST_QUIET = 2'd1,
        ST_RUN   = 2'd2
    } mode_t;
endpackage

// File: rtl/dpwm_frame_ctr.sv
// Free-running frame counter; the length is taken at each wrap.
module dpwm_frame_ctr #(
    parameter int CNT_W   = 8,
    parameter int DEF_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] frame_len,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LEN_RST = CNT_W'(DEF_LEN);

    logic [CNT_W-1:0] len_q;

    assign wrap = (cnt == len_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            len_q <= LEN_RST;
        end else if (wrap) begin
            cnt   <= '0;
            len_q <= frame_len;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dpwm_duty_map.sv
// Maps a signed sample to a high-time count, clipped below full modulation.
module dpwm_duty_map #(
    parameter int CNT_W   = 8,
    parameter int SMP_W   = 8,
    parameter int DEF_LEN = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    quiet,
    input  logic signed [SMP_W-1:0] sample,
    input  logic [CNT_W-1:0]        frame_len,
    output logic [CNT_W-1:0]        hi_q
);
    localparam int EW = CNT_W + 1;
    localparam logic signed [EW-1:0] ONE = EW'(1);
    localparam logic [CNT_W-1:0] HI_RST = CNT_W'(DEF_LEN / 2);

    logic signed [EW-1:0] half_s;
    logic signed [EW-1:0] lim_s;
    logic signed [EW-1:0] smp_s;
    logic signed [EW-1:0] off_s;
    logic signed [EW-1:0] sum_s;
    logic [CNT_W-1:0]     hi_d;

    always_comb begin
        half_s = $signed({1'b0, frame_len >> 1});
        lim_s  = half_s - (half_s >>> 4) - ONE;
        smp_s  = EW'(sample);
        if (smp_s > lim_s)
            off_s = lim_s;
        else if (smp_s < -lim_s)
            off_s = -lim_s;
        else
            off_s = smp_s;
        sum_s = half_s + off_s;
        hi_d  = quiet ? (frame_len >> 1) : sum_s[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_q <= HI_RST;
        else if (load)
            hi_q <= hi_d;
    end
endmodule

// File: rtl/dpwm_mode_fsm.sv
// Mode state machine: hard mute enters at once, other moves wait for a frame wrap.
module dpwm_mode_fsm
    import dpwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hard_mute,
    input  logic  quiet_mute,
    input  logic  wrap,
    output mode_t state
);
    mode_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HARD;
        else
            state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_HARD: begin
                if (!hard_mute && wrap)
                    state_d = quiet_mute ? ST_QUIET : ST_RUN;   // T_RELEASE_QUIET / T_RELEASE_RUN
            end
            ST_QUIET, ST_RUN: begin
                if (hard_mute)
                    state_d = ST_HARD;                          // T_HARD_ENTER
                else if (wrap)
                    state_d = quiet_mute ? ST_QUIET : ST_RUN;   // T_TO_QUIET / T_TO_RUN
            end
            default: state_d = ST_HARD;
        endcase
    end
endmodule

// File: rtl/dpwm_bridge_out.sv
// Differential two-state PWM output stage with quiet and hard mute.
module dpwm_bridge_out
    import dpwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int SMP_W   = 8,
    parameter int DEF_LEN = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hard_mute,
    input  logic                    quiet_mute,
    input  logic signed [SMP_W-1:0] pcm_sample,
    input  logic [CNT_W-1:0]        frame_len,
    output logic                    pwm_p,
    output logic                    pwm_m,
    output logic                    frame_start
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [CNT_W-1:0] hi_q;
    mode_t            state;
    logic             drive_hi;

    dpwm_frame_ctr #(.CNT_W(CNT_W), .DEF_LEN(DEF_LEN)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_len (frame_len),
        .cnt       (cnt),
        .wrap      (wrap)
    );

    dpwm_duty_map #(.CNT_W(CNT_W), .SMP_W(SMP_W), .DEF_LEN(DEF_LEN)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wrap),
        .quiet     (quiet_mute),
        .sample    (pcm_sample),
        .frame_len (frame_len),
        .hi_q      (hi_q)
    );

    dpwm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hard_mute  (hard_mute),
        .quiet_mute (quiet_mute),
        .wrap       (wrap),
        .state      (state)
    );

    assign drive_hi = (cnt < hi_q);

    // Registered outputs keep the comparator's glitches away from the bridge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_p       <= 1'b0;
            pwm_m       <= 1'b1;
            frame_start <= 1'b0;
        end else begin
            frame_start <= (cnt == '0);
            unique case (state)
                ST_HARD: begin
                    pwm_p <= 1'b0;
                    pwm_m <= 1'b1;
                end
                ST_QUIET, ST_RUN: begin
                    pwm_p <= drive_hi;
                    pwm_m <= !drive_hi;
                end
                default: begin
                    pwm_p <= 1'b0;
                    pwm_m <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/dpwm_bridge_chk.sv
module dpwm_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic hard_mute,
    input logic pwm_p,
    input logic pwm_m,
    input logic frame_start
);
    logic       p_d;
    logic [1:0] falls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_d   <= 1'b0;
            falls <= '0;
        end else begin
            p_d <= pwm_p;
            if (frame_start)
                falls <= '0;
            else if (p_d && !pwm_p && falls != 2'd3)
                falls <= falls + 1'b1;
        end
    end

    a_r1_two_state: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_p != pwm_m);

    a_r3_hard_park: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_mute && $past(hard_mute)) |=> (!pwm_p && pwm_m));

    a_r5_frame_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !$past(pwm_p));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        falls <= 2'd1);

    a_r9_no_back_to_back_start: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && $past(frame_start)));
endmodule

bind dpwm_bridge_out dpwm_bridge_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hard_mute   (hard_mute),
    .pwm_p       (pwm_p),
    .pwm_m       (pwm_m),
    .frame_start (frame_start)
);

// File: tb/sim_dpwm_bridge_out.sv
`timescale 1ns/1ps
module sim_dpwm_bridge_out;
    typedef struct {
        int    hi;
        int    len;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hard_mute = 1'b0;
    logic              quiet_mute = 1'b0;
    logic signed [7:0] pcm_sample = '0;
    logic [7:0]        frame_len = 8'd64;
    logic              pwm_p;
    logic              pwm_m;
    logic              frame_start;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    bit   last_hard = 1;
    exp_t q[$];

    always #4 clk = ~clk;

    dpwm_bridge_out u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .hard_mute   (hard_mute),
        .quiet_mute  (quiet_mute),
        .pcm_sample  (pcm_sample),
        .frame_len   (frame_len),
        .pwm_p       (pwm_p),
        .pwm_m       (pwm_m),
        .frame_start (frame_start)
    );

    function automatic int exp_hi(bit hard, bit quiet, int s, int len);
        int half = len / 2;
        int lim  = half - half / 16 - 1;
        int off  = s;
        if (hard) return 0;
        if (quiet) return half;
        if (off > lim) off = lim;
        if (off < -lim) off = -lim;
        return half + off;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Driver: set inputs for the next frame and queue what it should look like.
    task automatic drive_frame(bit hard, bit quiet, int s, int len, bit glitch, string tag);
        exp_t e;
        do @(negedge clk); while (!frame_start);
        hard_mute  = hard;
        quiet_mute = quiet;
        pcm_sample = 8'(s);
        frame_len  = 8'(len);
        // R3: entering hard mute cuts the running frame after two output cycles.
        if (hard && !last_hard && q.size() > 0 && q[$].hi > 2)
            q[$].hi = 2;
        last_hard = hard;
        e.hi  = exp_hi(hard, quiet, s, len);
        e.len = len;
        e.tag = tag;
        q.push_back(e);
        if (glitch) begin
            // R6: disturb inputs mid-frame, restore before the boundary.
            repeat (3) @(negedge clk);
            pcm_sample = 8'(-s - 40);
            frame_len  = 8'd20;
            quiet_mute = !quiet;
            repeat (4) @(negedge clk);
            pcm_sample = 8'(s);
            frame_len  = 8'(len);
            quiet_mute = quiet;
        end
    endtask

    // Monitor: measure each frame between frame_start marks, compare with queue head.
    initial begin
        int   hi_cnt = 0;
        int   len_cnt = 0;
        bit   started = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                check(pwm_p != pwm_m, "R1 complement", int'(pwm_p), int'(!pwm_m));
                if (frame_start) begin
                    if (started && q.size() > 0) begin
                        e = q.pop_front();
                        check(hi_cnt == e.hi, {e.tag, " high cycles"}, hi_cnt, e.hi);
                        check(len_cnt == e.len, {"R9 frame length ", e.tag}, len_cnt, e.len);
                    end
                    started = 1;
                    hi_cnt  = 0;
                    len_cnt = 0;
                end
                if (started) begin
                    len_cnt++;
                    if (pwm_p) hi_cnt++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_t e0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check(pwm_p == 1'b0, "R2 reset p", int'(pwm_p), 0);
        check(pwm_m == 1'b1, "R2 reset m", int'(pwm_m), 1);
        check(frame_start == 1'b0, "R2 reset frame_start", int'(frame_start), 0);
        e0.hi = 0; e0.len = 64; e0.tag = "R2 first frame";
        q.push_back(e0);
        rst_n = 1'b1;

        drive_frame(0, 0,    0, 64, 0, "R4 zero");
        drive_frame(0, 0,   10, 64, 0, "R4 positive");
        drive_frame(0, 0,  -20, 64, 0, "R4 negative");
        drive_frame(0, 0,  127, 64, 0, "R5 clip high");
        drive_frame(0, 0, -128, 64, 0, "R5 clip low");
        drive_frame(0, 1,  100, 64, 0, "R7 quiet");
        drive_frame(0, 0,    5, 16, 0, "R9 short frame");
        drive_frame(0, 0, -100, 16, 0, "R5 short clip");
        drive_frame(0, 0,   60, 100, 0, "R9 long frame");
        drive_frame(0, 0,    7, 64, 1, "R6 mid-frame change");
        drive_frame(1, 1,   30, 64, 0, "R8 hard over quiet");
        drive_frame(1, 0,  -30, 64, 0, "R3 hard held");
        drive_frame(0, 1,   40, 64, 0, "R10 release to quiet");
        drive_frame(0, 1,  -50, 64, 0, "R8 quiet over data");
        drive_frame(0, 0,   20, 64, 0, "R10 back to data");
        drive_frame(0, 0,   20, 64, 0, "R4 repeat");

        repeat (2) begin
            do @(negedge clk); while (!frame_start);
        end
        @(negedge clk);
        check(q.size() <= 1, "R9 frames drained", q.size(), 1);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule